// File: doc/BRIEF.md
# Rotating Single-Pulse Phase Controller

This block is the digital core of a multiphase buck regulator whose phases are never on together. A single pulse source serves every phase. Each new pulse is handed to the next phase in a fixed rotation, so each inductor sees the same switching rate while only one switch conducts at a time. Pulses are launched from an internal timebase. The period of that timebase is a programmable number of clock cycles.

A pulse stops early when an external comparator reports that the regulated output has gone above its reference. This comparator is asynchronous and is synchronized inside the block. If the comparator does not stop the pulse, a programmable maximum on-time cuts it. That cut limits duty cycle and power, and the output is left to sag. When many pulses in a row end on the cap, the block treats it as an overload and latches a shutdown flag. The flag holds every gate off until reset. Gate drivers, dead time and the analog comparator itself sit outside this block.

Top module: `phase_steer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all gate enables are 0 and the fault flag is 0. The first pulse after reset goes to phase 0.
- R2: At most one bit of `gate_en` is 1 in any cycle.
- R3: Pulses go to phases in the order 0, 1, …, NPH-1, 0, and so on. The rotation advances only when a pulse is actually launched.
- R4: The effective period is `period_cyc`, or 2 when `period_cyc` is below 2. A launch opportunity (tick) occurs every effective-period cycles while running. A pulse that launches on a tick shows on `gate_en` from the next cycle.
- R5: While the comparator stays low, a pulse lasts exactly cap cycles. The cap is `on_max` clamped to the effective period. When `on_max` is 0, no pulse is launched.
- R6: The comparator passes through a two-flop synchronizer. A pulse ends on the third rising edge after `cmp_above` rises, so it is visible for three samples if it started in the cycle in which the comparator rose.
- R7: A tick that falls while the synchronized comparator is high launches nothing.
- R8: Each pulse that ends on the cap adds one to a consecutive-overload count. Each pulse that ends on the comparator clears that count. `fault` rises on the edge that ends the cap-limited pulse bringing the count to `ovl_limit`. A value of 0 for `ovl_limit` acts as 1.
- R9: Once set, `fault` stays 1 until reset, whatever `enable` does. While it is set, all gate enables are 0.
- R10: With `enable` low, `gate_en` is 0 in that same cycle, and any pulse in progress is dropped without counting. The timebase restarts, so the first cycle with `enable` high again is a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_above | input | 1 | Asynchronous comparator: 1 when the output is above the reference |
| period_cyc | input | CNT_W | Pulse period in clock cycles (below 2 acts as 2) |
| on_max | input | CNT_W | Maximum on-time in clock cycles, clamped to the period |
| ovl_limit | input | OVL_W | Count of consecutive cap-limited pulses that trips the fault (0 acts as 1) |
| enable | input | 1 | Run control; low holds all gates off |
| gate_en | output | NPH | One-hot gate enable, bit i drives phase i |
| fault | output | 1 | Latched overload shutdown flag |

## Verification
Wrong internal state shows up at the ports within at most one period. A broken rotation pointer sends the next pulse to a phase other than the successor of the last one. A broken on-time counter changes the width of the very next cap-limited pulse. A synchronizer of the wrong depth moves the comparator-driven turn-off by a cycle. A wrong overload count moves the edge where `fault` rises, by whole pulses. The bench compares a cycle model against both outputs on every cycle, and directed cases pin down pulse width, spacing, order and the fault edge.

// File: rtl/phase_steer_pkg.sv
// Shared types for the rotating single-pulse phase controller.
// Assumes: consumers import the package; no state lives here.
package phase_steer_pkg;

    // Why a pulse ended in a given cycle (valid for one cycle only).
    typedef enum logic [1:0] {
        PE_NONE = 2'd0,
        PE_CMP  = 2'd1,
        PE_CAP  = 2'd2
    } pend_e;

endpackage

// File: rtl/cmp_sync.sv
// Brings the asynchronous comparator level into the clock domain.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_async,
    output logic cmp_s
);

    logic [STAGES-1:0] shreg;

    // Shift the raw comparator level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], cmp_async};
    end

    assign cmp_s = shreg[STAGES-1];

endmodule

// File: rtl/pulse_timebase.sv
// Produces one tick every effective period while running.
// Assumes: a period below 2 is raised to 2, so ticks are never adjacent.
// The counter is held at 0 while not running, so a tick comes on the first
// running cycle.
module pulse_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period_cyc,
    output logic [CNT_W-1:0] eff_per,
    output logic             tick
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    logic [CNT_W-1:0] cnt;

    // Clamp the programmed period to its minimum.
    always_comb begin
        eff_per = (period_cyc < MIN_PER) ? MIN_PER : period_cyc;
    end

    // Free-running period counter, restarted whenever the block stops.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (!run)                      cnt <= '0;
        else if (cnt >= eff_per - CNT_W'(1)) cnt <= '0;
        else                                cnt <= cnt + CNT_W'(1);
    end

    assign tick = run && (cnt == '0);

    // R4: ticks are at least two cycles apart.
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pulse_engine.sv
// Launches one pulse per tick and steers it to the next phase in rotation.
// It ends the pulse on the synchronized comparator or at the on-time cap.
// Assumes: cap <= effective period, supplied by the parent; run low aborts.
module pulse_engine
    import phase_steer_pkg::*;
#(
    parameter int NPH   = 5,
    parameter int CNT_W = 8,
    localparam int IDX_W = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             cmp_s,
    input  logic [CNT_W-1:0] cap,
    output logic             active,
    output logic [IDX_W-1:0] phase_idx,
    output pend_e            end_cause
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPH - 1);

    logic [CNT_W-1:0] on_cnt;
    logic [IDX_W-1:0] nxt_idx;
    logic             start;
    logic             end_cmp;
    logic             end_cap;

    // Successor phase in the rotation.
    always_comb begin
        nxt_idx = (phase_idx == LAST_IDX) ? '0 : phase_idx + IDX_W'(1);
    end

    // Launch and termination conditions for the current cycle.
    always_comb begin
        start   = tick && !cmp_s && (cap != '0);
        end_cmp = run && active && cmp_s;
        end_cap = run && active && !cmp_s && (on_cnt >= cap);
    end

    // Report the cause of a pulse ending to the overload guard.
    always_comb begin
        if (end_cmp)      end_cause = PE_CMP;
        else if (end_cap) end_cause = PE_CAP;
        else              end_cause = PE_NONE;
    end

    // Pulse state, on-time counter and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            on_cnt    <= '0;
            phase_idx <= LAST_IDX;
        end else if (!run) begin
            active <= 1'b0;
            on_cnt <= '0;
        end else if (start) begin
            active    <= 1'b1;
            on_cnt    <= CNT_W'(1);
            phase_idx <= nxt_idx;
        end else if (end_cmp || end_cap) begin
            active <= 1'b0;
            on_cnt <= '0;
        end else if (active) begin
            on_cnt <= on_cnt + CNT_W'(1);
        end
    end

    // R3: the pointer only moves one step forward, wrapping at the last phase.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_idx) |->
            (phase_idx == (($past(phase_idx) == LAST_IDX) ? '0
                                                          : $past(phase_idx) + IDX_W'(1))));

    // R5: a pulse at its cap with no tick pending is off in the next cycle.
    a_r5_cap_end: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cmp_s && (on_cnt >= cap) && !tick) |=> !active);

    // R7: no pulse starts while the synchronized comparator is high.
    a_r7_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_s && !active) |=> !active);

endmodule

// File: rtl/overload_guard.sv
// Counts consecutive cap-limited pulses and latches the shutdown flag.
// Assumes: end_cause is a single-cycle report; a limit of 0 acts as 1.
module overload_guard
    import phase_steer_pkg::*;
#(
    parameter int OVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pend_e            end_cause,
    input  logic [OVL_W-1:0] ovl_limit,
    output logic             fault
);

    localparam logic [OVL_W-1:0] CNT_MAX = {OVL_W{1'b1}};

    logic [OVL_W-1:0] ovl_cnt;
    logic [OVL_W:0]   lim_eff;
    logic [OVL_W:0]   cnt_next;

    // Effective limit and the count this pulse would reach.
    always_comb begin
        lim_eff  = (ovl_limit == '0) ? (OVL_W+1)'(1) : {1'b0, ovl_limit};
        cnt_next = {1'b0, ovl_cnt} + (OVL_W+1)'(1);
    end

    // Consecutive overload counter: saturating up on cap, clear on comparator.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       ovl_cnt <= '0;
        else if (end_cause == PE_CMP)                     ovl_cnt <= '0;
        else if (end_cause == PE_CAP && ovl_cnt != CNT_MAX) ovl_cnt <= ovl_cnt + OVL_W'(1);
    end

    // Latch the fault when the count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         fault <= 1'b0;
        else if (end_cause == PE_CAP && cnt_next >= lim_eff) fault <= 1'b1;
    end

    // R8: a comparator-ended pulse clears the count.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cause == PE_CMP) |=> (ovl_cnt == '0));

    // R9: the fault never clears except by reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

endmodule

// File: rtl/phase_steer_ctrl.sv
// Top level: rotating single-pulse phase controller for a multiphase buck.
// It wires the synchronizer, timebase, pulse engine and overload guard,
// clamps the on-time cap to the period and decodes the one-hot gate enables.
// Assumes: NPH >= 2; the comparator is asynchronous; gates feed external drivers.
module phase_steer_ctrl
    import phase_steer_pkg::*;
#(
    parameter int NPH         = 5,
    parameter int CNT_W       = 8,
    parameter int OVL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_above,
    input  logic [CNT_W-1:0] period_cyc,
    input  logic [CNT_W-1:0] on_max,
    input  logic [OVL_W-1:0] ovl_limit,
    input  logic             enable,
    output logic [NPH-1:0]   gate_en,
    output logic             fault
);

    localparam int IDX_W = (NPH > 1) ? $clog2(NPH) : 1;

    logic             cmp_s;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] eff_per;
    logic [CNT_W-1:0] cap;
    logic             active;
    logic [IDX_W-1:0] phase_idx;
    pend_e            end_cause;

    // The block runs only when enabled and not in fault.
    assign run = enable && !fault;

    // Clamp the maximum on-time to the effective period.
    always_comb begin
        cap = (on_max > eff_per) ? eff_per : on_max;
    end

    cmp_sync #(
        .STAGES    (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_async (cmp_above),
        .cmp_s     (cmp_s)
    );

    pulse_timebase #(
        .CNT_W      (CNT_W)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .period_cyc (period_cyc),
        .eff_per    (eff_per),
        .tick       (tick)
    );

    pulse_engine #(
        .NPH       (NPH),
        .CNT_W     (CNT_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .cmp_s     (cmp_s),
        .cap       (cap),
        .active    (active),
        .phase_idx (phase_idx),
        .end_cause (end_cause)
    );

    overload_guard #(
        .OVL_W     (OVL_W)
    ) u_ovl (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_cause (end_cause),
        .ovl_limit (ovl_limit),
        .fault     (fault)
    );

    // One decoder per phase: gate on only for the selected, running pulse.
    for (genvar g = 0; g < NPH; g++) begin : g_gate
        assign gate_en[g] = run && active && (phase_idx == IDX_W'(g));
    end

    // R2: never more than one phase conducting.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_en));

    // R9: once faulted, the pulse engine is idle from the next cycle.
    a_r9_idle_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !active);

    // R10: disabling drops any pulse at the next edge.
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !active);

endmodule

// File: tb/test_phase_steer_ctrl.sv
// Self-checking bench: cycle model plus directed corner cases and seeded random traffic.
module test_phase_steer_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NPH   = 5;
    localparam int CNT_W = 8;
    localparam int OVL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_above = 1'b0;
    logic [CNT_W-1:0] period_cyc = 8'd6;
    logic [CNT_W-1:0] on_max = 8'd3;
    logic [OVL_W-1:0] ovl_limit = 4'd15;
    logic             enable = 1'b0;
    logic [NPH-1:0]   gate_en;
    logic             fault;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_steer_ctrl #(.NPH(NPH), .CNT_W(CNT_W), .OVL_W(OVL_W)) i_phase_steer_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above), .period_cyc(period_cyc),
        .on_max(on_max), .ovl_limit(ovl_limit), .enable(enable),
        .gate_en(gate_en), .fault(fault)
    );

    // ---------------- reference model (from the requirements) ----------------
    int m_cnt, m_on, m_idx, m_ocnt;
    bit m_f1, m_f2, m_act, m_fault;
    int ep, cp, lm;
    bit mrun, mtick, mst, mec, mea;

    function automatic int eff_period(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int eff_cap(int m, int p);
        return (m > eff_period(p)) ? eff_period(p) : m;
    endfunction

    function automatic int exp_gate();
        return (m_act && enable && !m_fault) ? (1 << m_idx) : 0;
    endfunction

    always @(posedge clk) begin
        ep = eff_period(int'(period_cyc));
        cp = eff_cap(int'(on_max), int'(period_cyc));
        lm = (ovl_limit == 0) ? 1 : int'(ovl_limit);
        if (!rst_n) begin
            m_cnt = 0; m_on = 0; m_idx = NPH-1; m_ocnt = 0;
            m_f1 = 0; m_f2 = 0; m_act = 0; m_fault = 0;
        end else begin
            mrun  = enable && !m_fault;
            mtick = mrun && (m_cnt == 0);
            mec   = mrun && m_act && m_f2;
            mea   = mrun && m_act && !m_f2 && (m_on >= cp);
            mst   = mtick && !m_f2 && (cp != 0);
            if (!mrun) begin
                m_cnt = 0; m_act = 0; m_on = 0;
            end else begin
                m_cnt = (m_cnt >= ep-1) ? 0 : m_cnt + 1;
                if (mst) begin
                    m_act = 1; m_on = 1; m_idx = (m_idx + 1) % NPH;
                end else if (mec || mea) begin
                    m_act = 0; m_on = 0;
                end else if (m_act) begin
                    m_on = m_on + 1;
                end
            end
            if (mec) m_ocnt = 0;
            else if (mea) begin
                if (m_ocnt + 1 >= lm) m_fault = 1;
                if (m_ocnt < 15) m_ocnt = m_ocnt + 1;
            end
            m_f2 = m_f1;
            m_f1 = cmp_above;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Pulse monitor state, updated from the ports at every sample.
    logic [NPH-1:0] prev_g = '0;
    int width = 0, last_width = 0, last_phase = -1, first_phase = -1;
    int rot_bad = 0, starts = 0, last_start = 0, gap = 0, cyc = 0;

    function automatic int ph_of(logic [NPH-1:0] g);
        for (int i = 0; i < NPH; i++) if (g[i]) return i;
        return -1;
    endfunction

    // One clock: sample at the falling edge, compare with the model, track pulses.
    task automatic step();
        int ph;
        @(negedge clk);
        if (rst_n) begin
            chk(gate_en == NPH'(exp_gate()),
                ($countones(gate_en) > 1) ? "R2 gate" : "R3 R4 R5 R6 R7 R10 gate (model)",
                int'(gate_en), exp_gate());
            chk(fault == m_fault, "R8 R9 fault (model)", int'(fault), int'(m_fault));
        end
        if (gate_en != 0 && gate_en != prev_g) begin
            ph = ph_of(gate_en);
            if (last_phase >= 0 && ph != (last_phase + 1) % NPH) rot_bad++;
            if (last_phase < 0) first_phase = ph;
            last_phase = ph;
            starts++;
            gap = cyc - last_start;
            last_start = cyc;
            if (prev_g != 0) last_width = width;
            width = 1;
        end else if (gate_en != 0) begin
            width++;
        end else if (prev_g != 0) begin
            last_width = width;
            width = 0;
        end
        prev_g = gate_en;
        cyc++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_starts(input int n);
        for (int i = 0; i < 200 && starts < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        steps(3);
        rst_n = 1'b1;
        last_phase = -1; first_phase = -1; rot_bad = 0; starts = 0;
    endtask

    task automatic cfg(input int p, input int m, input int l);
        period_cyc = CNT_W'(p); on_max = CNT_W'(m); ovl_limit = OVL_W'(l);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int s0;
        void'($urandom(32'd20240611));

        // R1: reset state
        enable = 0; cmp_above = 0;
        do_reset();
        step();
        chk(gate_en == 0, "R1 gates after reset", int'(gate_en), 0);
        chk(fault == 0, "R1 fault after reset", int'(fault), 0);

        // R3 R4 R5: steady cap-limited pulsing
        cfg(6, 3, 15); enable = 1;
        steps(40);
        chk(first_phase == 0, "R1 first pulse on phase 0", first_phase, 0);
        chk(rot_bad == 0, "R3 rotation order", rot_bad, 0);
        chk(last_width == 3, "R5 capped width", last_width, 3);
        chk(gap == 6, "R4 pulse spacing", gap, 6);

        // R6 R7: comparator-terminated pulse, then suppressed ticks
        enable = 0; do_reset(); cfg(10, 8, 15); enable = 1;
        wait_starts(1);
        cmp_above = 1;
        steps(5);
        chk(last_width == 3, "R6 comparator end latency", last_width, 3);
        s0 = starts;
        steps(25);
        chk(starts == s0, "R7 no launch while above", starts - s0, 0);
        cmp_above = 0;
        steps(25);
        chk(rot_bad == 0, "R3 R7 rotation not advanced by skipped ticks", rot_bad, 0);

        // R10: disable mid-pulse, then immediate restart
        enable = 0; do_reset(); cfg(8, 6, 15); enable = 1;
        wait_starts(2);
        enable = 0;
        #1;
        chk(gate_en == 0, "R10 gate off same cycle", int'(gate_en), 0);
        steps(3);
        enable = 1;
        step();
        chk(gate_en != 0, "R10 pulse right after re-enable", int'(gate_en != 0), 1);
        chk(rot_bad == 0, "R3 R10 rotation after abort", rot_bad, 0);

        // R5: zero on-time launches nothing
        enable = 0; do_reset(); cfg(5, 0, 15); enable = 1;
        steps(30);
        chk(starts == 0, "R5 on_max zero", starts, 0);

        // R4 R5: period and cap clamped to 2
        enable = 0; do_reset(); cfg(0, 9, 15); enable = 1;
        steps(20);
        chk(gap == 2, "R4 minimum period", gap, 2);
        chk(last_width == 2, "R5 cap clamped to period", last_width, 2);

        // R8 R9: fault on the fourth cap-limited pulse, latched
        enable = 0; do_reset(); cfg(4, 2, 4); enable = 1;
        steps(40);
        chk(fault == 1, "R8 fault after limit", int'(fault), 1);
        chk(starts == 4, "R8 exactly limit pulses", starts, 4);
        chk(gate_en == 0, "R9 gates off in fault", int'(gate_en), 0);
        enable = 0; steps(3); enable = 1; steps(5);
        chk(fault == 1, "R9 fault survives enable toggle", int'(fault), 1);
        do_reset(); step();
        chk(fault == 0, "R1 reset clears fault", int'(fault), 0);

        // R8: limit 0 acts as 1
        enable = 0; do_reset(); cfg(4, 2, 0); enable = 1;
        steps(10);
        chk(fault == 1 && starts == 1, "R8 limit zero acts as one", starts, 1);

        // R8: comparator-ended pulse clears the count
        enable = 0; do_reset(); cfg(10, 4, 3); enable = 1;
        wait_starts(3);
        cmp_above = 1; steps(4); cmp_above = 0;
        wait_starts(6);
        chk(fault == 0, "R8 count cleared by comparator", int'(fault), 0);
        steps(6);
        chk(fault == 1, "R8 third consecutive cap pulse trips", int'(fault), 1);

        // Random traffic checked cycle by cycle against the model
        for (int blk = 0; blk < 40; blk++) begin
            enable = 0;
            step();
            cfg($urandom_range(0, 12), $urandom_range(0, 14), $urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) do_reset();
            enable = 1;
            for (int c = 0; c < 60; c++) begin
                if ($urandom_range(0, 5) == 0) cmp_above = ~cmp_above;
                if ($urandom_range(0, 39) == 0) enable = ~enable;
                step();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule